// File: doc/BRIEF.md
# Inter-bank command spacing guard for non-volatile memory

This block sits between a memory controller's command picker and the command bus of one rank of non-volatile memory. In every cycle the picker shows it one candidate command: activate, read, write or precharge, together with a bank number. The block answers at once whether that command may go out in this cycle without breaking the rank-wide spacing rules. These rules keep the peak supply current within limits when slow, current-hungry array writes overlap with row activations. The block also reports a legality bit for each of the four command types, evaluated for the candidate bank.

All limits are run-time inputs given as whole controller cycles, which is the device time divided by the clock period. The block checks the usual activation limits: no more than four activations in a rolling window, and a minimum gap between activations to different banks. It adds three limits for long writes: write to write, write to activate, and activate to write. History changes only when the picker pulses the issue strobe. It keeps saturating elapsed-cycle counters for the last four activations, the most recent activation and its bank, and the most recent write. Reads and precharges never stall here. Per-bank row timing is handled elsewhere.

Top module: `nvm_cmd_spacer`

## Requirements
- R1: After reset is released, activate and write are both legal for any limit values until the first command is issued.
- R2: Command codes are activate 0, read 1, write 2, precharge 3. `legal[c]` is the legality of code c, and `cand_ok` equals `legal[cand_cmd]`. Read and precharge are always legal.
- R3: Once four activations have been issued, a further activation is illegal while the oldest of the last four was issued fewer than `cfg_faw` cycles ago. It is legal from exactly `cfg_faw` cycles on.
- R4: An activation to a bank other than the last activated bank is illegal until `cfg_rrd` cycles after that activation. An activation to the same bank is not held by this limit.
- R5: A write is illegal until `cfg_wwd` cycles after the previous write.
- R6: An activation is illegal until `cfg_wad` cycles after the most recent write.
- R7: A write is illegal until `cfg_awd` cycles after the most recent activation.
- R8: Only a cycle with `issue_vld` high changes the history. A candidate that is presented without the strobe leaves all later answers unchanged.
- R9: A command strobed at one clock edge and a query evaluated N edges later are N cycles apart, so N at or above the limit is legal. A limit of 0 or 1 never stalls.
- R10: Elapsed counts saturate and do not wrap. After any idle time at or above a limit, that limit stays satisfied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all history |
| cfg_faw | input | CNT_W | Rolling four-activation window, cycles |
| cfg_rrd | input | CNT_W | Activate-to-activate gap for different banks, cycles |
| cfg_wwd | input | CNT_W | Write-to-write gap, cycles |
| cfg_wad | input | CNT_W | Write-to-activate gap, cycles |
| cfg_awd | input | CNT_W | Activate-to-write gap, cycles |
| cand_cmd | input | 2 | Candidate command code |
| cand_bank | input | BANK_W | Candidate bank |
| issue_vld | input | 1 | Strobe: a command goes out this cycle |
| issue_cmd | input | 2 | Code of the command going out |
| issue_bank | input | BANK_W | Bank of the command going out |
| legal | output | 4 | Legality for each command code, for cand_bank |
| cand_ok | output | 1 | Legality of the candidate command |

## Verification
A wrong history shows up as a legality bit that is wrong at a boundary. A stall may last one cycle too long or end one cycle too early, or an activation may pass inside the window, or a stall may come back after a long idle time when a counter wraps. The model in the bench keeps issue times in cycles and compares both the legality vector and `cand_ok` in every cycle. A miscount is therefore reported in the first cycle where the model's answer and the design's answer differ. This is at most one cycle after the limit is crossed. Queries without the strobe are placed next to limit boundaries, so any history update on a query is seen within the same window.

// File: rtl/nvm_spc_pkg.sv
package nvm_spc_pkg;
    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } nvm_cmd_e;

    localparam int NUM_CMDS = 4;
endpackage

// File: rtl/nvm_spc_age.sv
// Saturating elapsed-cycle tracker for one event: loads 1 on the event,
// counts up each cycle, holds at the top value.
module nvm_spc_age #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    output logic [CNT_W-1:0] age_o,
    output logic             vld_o
);
    localparam logic [CNT_W-1:0] AGE_TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] AGE_ONE = CNT_W'(1);

    typedef struct packed {
        logic             vld;
        logic [CNT_W-1:0] age;
    } age_st_t;

    age_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.vld && (st_q.age != AGE_TOP)) begin
            st_d.age = st_q.age + AGE_ONE;
        end
        if (load_i) begin
            st_d.vld = 1'b1;
            st_d.age = AGE_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign age_o = st_q.age;
    assign vld_o = st_q.vld;
endmodule

// File: rtl/nvm_spc_faw_ring.sv
// Circular log of the last DEPTH activations; the slot at the write
// pointer is always the oldest once the log is full.
module nvm_spc_faw_ring #(
    parameter int CNT_W = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    output logic [CNT_W-1:0] oldest_age_o,
    output logic             oldest_vld_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ring_st_t;

    ring_st_t ring_d, ring_q;

    logic [CNT_W-1:0] slot_age [DEPTH];
    logic             slot_vld [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        nvm_spc_age #(.CNT_W(CNT_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (push_i && (ring_q.ptr == PTR_W'(gi))),
            .age_o  (slot_age[gi]),
            .vld_o  (slot_vld[gi])
        );
    end

    always_comb begin
        ring_d = ring_q;
        if (push_i) begin
            ring_d.ptr = (ring_q.ptr == PTR_LAST) ? '0 : ring_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign oldest_age_o = slot_age[ring_q.ptr];
    assign oldest_vld_o = slot_vld[ring_q.ptr];
endmodule

// File: rtl/nvm_spc_rules.sv
// Pure combinational evaluation of all spacing limits.
module nvm_spc_rules #(
    parameter int CNT_W  = 8,
    parameter int BANK_W = 3
) (
    input  logic [CNT_W-1:0]  cfg_faw,
    input  logic [CNT_W-1:0]  cfg_rrd,
    input  logic [CNT_W-1:0]  cfg_wwd,
    input  logic [CNT_W-1:0]  cfg_wad,
    input  logic [CNT_W-1:0]  cfg_awd,
    input  logic [CNT_W-1:0]  win_age,
    input  logic              win_vld,
    input  logic [CNT_W-1:0]  act_age,
    input  logic              act_vld,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [CNT_W-1:0]  wr_age,
    input  logic              wr_vld,
    input  logic [BANK_W-1:0] cand_bank,
    output logic              act_ok,
    output logic              wr_ok
);
    function automatic logic far_enough(input logic vld,
                                        input logic [CNT_W-1:0] age,
                                        input logic [CNT_W-1:0] lim);
        return !vld || (age >= lim);
    endfunction

    logic win_ok, rrd_ok, wad_ok, wwd_ok, awd_ok, same_bank;

    always_comb begin
        same_bank = (cand_bank == act_bank);
        win_ok    = far_enough(win_vld, win_age, cfg_faw);
        rrd_ok    = same_bank || far_enough(act_vld, act_age, cfg_rrd);
        wad_ok    = far_enough(wr_vld, wr_age, cfg_wad);
        wwd_ok    = far_enough(wr_vld, wr_age, cfg_wwd);
        awd_ok    = far_enough(act_vld, act_age, cfg_awd);
        act_ok    = win_ok && rrd_ok && wad_ok;
        wr_ok     = wwd_ok && awd_ok;
    end
endmodule

// File: rtl/nvm_cmd_spacer.sv
module nvm_cmd_spacer
    import nvm_spc_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int BANK_W  = 3,
    parameter int WIN_ACT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_faw,
    input  logic [CNT_W-1:0]  cfg_rrd,
    input  logic [CNT_W-1:0]  cfg_wwd,
    input  logic [CNT_W-1:0]  cfg_wad,
    input  logic [CNT_W-1:0]  cfg_awd,
    input  logic [1:0]        cand_cmd,
    input  logic [BANK_W-1:0] cand_bank,
    input  logic              issue_vld,
    input  logic [1:0]        issue_cmd,
    input  logic [BANK_W-1:0] issue_bank,
    output logic [3:0]        legal,
    output logic              cand_ok
);
    typedef struct packed {
        logic [BANK_W-1:0] act_bank;
    } top_st_t;

    top_st_t top_d, top_q;

    logic             push_act, push_wr;
    logic [CNT_W-1:0] win_age, act_age, wr_age;
    logic             win_vld, act_vld, wr_vld;
    logic             act_ok, wr_ok;

    assign push_act = issue_vld && (issue_cmd == CMD_ACT);
    assign push_wr  = issue_vld && (issue_cmd == CMD_WR);

    nvm_spc_faw_ring #(.CNT_W(CNT_W), .DEPTH(WIN_ACT)) u_ring (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push_act),
        .oldest_age_o (win_age),
        .oldest_vld_o (win_vld)
    );

    nvm_spc_age #(.CNT_W(CNT_W)) u_act_age (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (push_act),
        .age_o  (act_age),
        .vld_o  (act_vld)
    );

    nvm_spc_age #(.CNT_W(CNT_W)) u_wr_age (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (push_wr),
        .age_o  (wr_age),
        .vld_o  (wr_vld)
    );

    always_comb begin
        top_d = top_q;
        if (push_act) begin
            top_d.act_bank = issue_bank;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    nvm_spc_rules #(.CNT_W(CNT_W), .BANK_W(BANK_W)) u_rules (
        .cfg_faw   (cfg_faw),
        .cfg_rrd   (cfg_rrd),
        .cfg_wwd   (cfg_wwd),
        .cfg_wad   (cfg_wad),
        .cfg_awd   (cfg_awd),
        .win_age   (win_age),
        .win_vld   (win_vld),
        .act_age   (act_age),
        .act_vld   (act_vld),
        .act_bank  (top_q.act_bank),
        .wr_age    (wr_age),
        .wr_vld    (wr_vld),
        .cand_bank (cand_bank),
        .act_ok    (act_ok),
        .wr_ok     (wr_ok)
    );

    always_comb begin
        legal          = '0;
        legal[CMD_ACT] = act_ok;
        legal[CMD_RD]  = 1'b1;
        legal[CMD_WR]  = wr_ok;
        legal[CMD_PRE] = 1'b1;
        cand_ok        = legal[cand_cmd];
    end
endmodule

// File: rtl/nvm_spc_chk.sv
module nvm_spc_chk #(
    parameter int CNT_W  = 8,
    parameter int BANK_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cfg_rrd,
    input logic [CNT_W-1:0]  cfg_wwd,
    input logic [CNT_W-1:0]  cfg_wad,
    input logic [CNT_W-1:0]  cfg_awd,
    input logic [BANK_W-1:0] cand_bank,
    input logic              issue_vld,
    input logic [1:0]        issue_cmd,
    input logic [BANK_W-1:0] issue_bank,
    input logic [3:0]        legal
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R1
    fresh_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (legal[0] && legal[2]));

    // R4
    act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_cmd == 2'd0) |=>
        ((cfg_rrd <= ONE) || (cand_bank == $past(issue_bank)) || !legal[0]));

    // R5
    wr_wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_cmd == 2'd2) |=> ((cfg_wwd <= ONE) || !legal[2]));

    // R6
    wr_act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_cmd == 2'd2) |=> ((cfg_wad <= ONE) || !legal[0]));

    // R7
    act_wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_cmd == 2'd0) |=> ((cfg_awd <= ONE) || !legal[2]));
endmodule

bind nvm_cmd_spacer nvm_spc_chk #(.CNT_W(CNT_W), .BANK_W(BANK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rrd    (cfg_rrd),
    .cfg_wwd    (cfg_wwd),
    .cfg_wad    (cfg_wad),
    .cfg_awd    (cfg_awd),
    .cand_bank  (cand_bank),
    .issue_vld  (issue_vld),
    .issue_cmd  (issue_cmd),
    .issue_bank (issue_bank),
    .legal      (legal)
);

// File: tb/sim_nvm_cmd_spacer.sv
module sim_nvm_cmd_spacer;
    localparam int CLK_P  = 10;
    localparam int CNT_W  = 8;
    localparam int BANK_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  cfg_faw = '0, cfg_rrd = '0, cfg_wwd = '0, cfg_wad = '0, cfg_awd = '0;
    logic [1:0]        cand_cmd = '0;
    logic [BANK_W-1:0] cand_bank = '0;
    logic              issue_vld = 1'b0;
    logic [1:0]        issue_cmd = '0;
    logic [BANK_W-1:0] issue_bank = '0;
    logic [3:0]        legal;
    logic              cand_ok;

    always #(CLK_P/2) clk = ~clk;

    nvm_cmd_spacer #(.CNT_W(CNT_W), .BANK_W(BANK_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_faw(cfg_faw), .cfg_rrd(cfg_rrd), .cfg_wwd(cfg_wwd),
        .cfg_wad(cfg_wad), .cfg_awd(cfg_awd),
        .cand_cmd(cand_cmd), .cand_bank(cand_bank),
        .issue_vld(issue_vld), .issue_cmd(issue_cmd), .issue_bank(issue_bank),
        .legal(legal), .cand_ok(cand_ok)
    );

    typedef struct {
        string      tag;
        logic [3:0] legal;
        logic       ok;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_bad = 0;

    // reference history in cycle numbers
    int n;
    int acts[$];
    int last_act;
    int last_bank;
    int last_wr;

    function automatic bit m_act_ok(int bank);
        bit w, r, a;
        w = (acts.size() < 4) || (n - acts[0] >= int'(cfg_faw));
        r = (last_act < 0) || (bank == last_bank) || (n - last_act >= int'(cfg_rrd));
        a = (last_wr < 0) || (n - last_wr >= int'(cfg_wad));
        return w && r && a;
    endfunction

    function automatic bit m_wr_ok();
        bit w, a;
        w = (last_wr < 0) || (n - last_wr >= int'(cfg_wwd));
        a = (last_act < 0) || (n - last_act >= int'(cfg_awd));
        return w && a;
    endfunction

    task automatic do_reset(int faw, int rrd, int wwd, int wad, int awd);
        @(negedge clk);
        rst_n = 1'b0;
        issue_vld = 1'b0;
        cfg_faw = CNT_W'(faw); cfg_rrd = CNT_W'(rrd); cfg_wwd = CNT_W'(wwd);
        cfg_wad = CNT_W'(wad); cfg_awd = CNT_W'(awd);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        acts.delete();
        last_act = -1;
        last_bank = 0;
        last_wr = -1;
    endtask

    // one cycle: present candidate, optionally issue it, record expectation
    task automatic run(int cmd, int bank, bit iss, string tag);
        exp_t e;
        @(negedge clk);
        cand_cmd   = 2'(cmd);
        cand_bank  = BANK_W'(bank);
        issue_vld  = iss;
        issue_cmd  = 2'(cmd);
        issue_bank = BANK_W'(bank);
        e.tag   = tag;
        e.legal = {1'b1, m_wr_ok(), 1'b1, m_act_ok(bank)};
        e.ok    = e.legal[cmd];
        sbq.push_back(e);
        if (iss && cmd == 0) begin
            acts.push_back(n);
            if (acts.size() > 4) void'(acts.pop_front());
            last_act  = n;
            last_bank = bank;
        end
        if (iss && cmd == 2) last_wr = n;
        n++;
    endtask

    task automatic act_when_legal(int bank, string tag);
        for (int i = 0; i < 300; i++) begin
            if (m_act_ok(bank)) begin
                run(0, bank, 1'b1, tag);
                break;
            end
            run(0, bank, 1'b0, tag);
        end
    endtask

    task automatic wr_when_legal(string tag);
        for (int i = 0; i < 300; i++) begin
            if (m_wr_ok()) begin
                run(2, 0, 1'b1, tag);
                break;
            end
            run(2, 0, 1'b0, tag);
        end
    endtask

    // monitor: compare a quarter period after each driving edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                n_chk++;
                if (legal !== e.legal) begin
                    n_bad++;
                    $display("FAIL %s legal act=%b exp=%b", e.tag, legal, e.legal);
                end
                n_chk++;
                if (cand_ok !== e.ok) begin
                    n_bad++;
                    $display("FAIL %s cand_ok act=%b exp=%b", e.tag, cand_ok, e.ok);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        // R1 and R2 on a fresh history
        do_reset(20, 3, 6, 5, 4);
        run(0, 0, 1'b0, "R1");
        run(2, 0, 1'b0, "R1");
        run(1, 0, 1'b0, "R2");
        run(3, 5, 1'b0, "R2");
        run(0, 0, 1'b1, "R3");
        // R4: other bank held, same bank exempt
        for (int i = 0; i < 4; i++) run(0, 1, 1'b0, "R4");
        run(0, 0, 1'b0, "R4");
        act_when_legal(1, "R4");
        act_when_legal(2, "R4");
        act_when_legal(3, "R4");
        // R3: fifth activation waits for the rolling window
        act_when_legal(4, "R3");
        wr_when_legal("R7");
        wr_when_legal("R5");
        act_when_legal(1, "R6");
        // R8: queries without the strobe do not touch history
        wr_when_legal("R8");
        for (int i = 0; i < 10; i++) run(2, 0, 1'b0, "R8");
        for (int i = 0; i < 6; i++) run(0, 6, 1'b0, "R8");
        run(1, 2, 1'b1, "R2");
        run(3, 2, 1'b1, "R2");
        // R9: random mix with moderate limits
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            run(int'(lf[1:0]), int'(lf[4:2]), lf[5], "R9");
        end
        // R9: limits of 0 and 1 never stall
        do_reset(0, 1, 0, 1, 0);
        for (int i = 0; i < 60; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            run(int'(lf[1:0]), int'(lf[4:2]), 1'b1, "R9");
        end
        // R10: full-scale limits, long idle, no wrap
        do_reset(255, 255, 255, 255, 255);
        run(0, 0, 1'b0, "R1");
        run(2, 0, 1'b0, "R1");
        run(0, 0, 1'b1, "R10");
        run(2, 0, 1'b1, "R10");
        for (int i = 0; i < 320; i++) run((i % 2 == 0) ? 0 : 2, 3, 1'b0, "R10");
        @(negedge clk);
        issue_vld = 1'b0;
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule